// File: doc/BRIEF.md
# Descriptor-Driven DMA Command Sequencer

This block runs a chain of command descriptors held in a small slot memory. Software, or a neighbouring block, fills the slots through a host port. It then pulses `start` with a first slot number. The sequencer fetches each descriptor and moves bytes through a one-beat-per-acknowledge handshake toward the device. After the transfer it may stall on a wait condition. It then writes a completion status word and the residual byte count back into the same slot. Finally it takes either the descriptor's branch target or the next slot, and it may raise a one-cycle interrupt.

Each descriptor carries three 2-bit policies: interrupt, branch and wait. Each policy is tested against its own selector pair, a mask and a value, applied to the 8-bit device status input. A selector hits when `(dev_status & mask) == value`. Execution ends when a stop descriptor is fetched.

Top module: `dsq_top`

## Requirements
- R1: After reset, `active`, `irq` and `xfer_req` are low, and every slot reads back status 0 and residual 0.
- R2: Host descriptor word layout (default widths): bits [27:25] opcode, [24:23] interrupt code, [22:21] branch code, [20:19] wait code, [18:16] branch target slot, [15:8] start address, [7:0] byte count. A host write to a slot clears that slot's status and residual, and these are then read back at `host_sts`/`host_res` for `host_slot`.
- R3: Opcodes 0 and 2 (output/input, more) move exactly the byte count, one byte per cycle with `xfer_ack` high. Addresses start at the descriptor address and rise by one per beat. `xfer_op` shows the opcode, `xfer_eop` is ignored, and a count of 0 moves nothing.
- R4: Opcodes 1 and 3 (output/input, last) end after the beat that carries `xfer_eop`. The residual written back is the count minus the beats accepted.
- R5: Opcodes 4 and 5 (quad store/load) make exactly one beat, whatever the count, and write back residual 0.
- R6: Opcode 6 (no-op) makes no beat and writes back the full count as its residual.
- R7: Opcode 7 (stop) makes no beat and writes nothing to its slot. `active` falls in the cycle after it is fetched.
- R8: Policy codes are 0 never, 1 when the selector hits, 2 when it misses, and 3 always.
- R9: When the branch policy holds at completion, the next slot is the descriptor's target. Otherwise it is the slot plus one, wrapping from the last slot to slot 0.
- R10: While the wait policy holds, the sequencer stays after the transfer and does not write back. The policy is re-evaluated every cycle.
- R11: The status written back is 0x8400 with bit 8 set when the branch was taken, ORed with the device status in bits [7:0] at completion.
- R12: When the interrupt policy holds at completion, `irq` is high for exactly the one cycle after the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin executing at `start_slot` when idle |
| start_slot | input | SLOT_W | First slot to run |
| dev_status | input | 8 | Device status bits tested by the selectors |
| int_mask | input | 8 | Interrupt selector mask |
| int_val | input | 8 | Interrupt selector value |
| br_mask | input | 8 | Branch selector mask |
| br_val | input | 8 | Branch selector value |
| wait_mask | input | 8 | Wait selector mask |
| wait_val | input | 8 | Wait selector value |
| host_we | input | 1 | Write `host_wdata` into slot `host_slot` |
| host_slot | input | SLOT_W | Slot for host write and read-back |
| host_wdata | input | DESC_W | Descriptor word |
| host_sts | output | 16 | Written-back status of `host_slot` |
| host_res | output | CNT_W | Written-back residual of `host_slot` |
| xfer_req | output | 1 | Beat requested toward the device |
| xfer_op | output | 3 | Opcode of the current transfer |
| xfer_addr | output | ADDR_W | Byte address of the current beat |
| xfer_ack | input | 1 | Device accepts the beat this cycle |
| xfer_eop | input | 1 | End of packet, valid with `xfer_ack` |
| irq | output | 1 | One-cycle interrupt pulse |
| active | output | 1 | Sequencer running a chain |

## Verification
The bench goes after the early end of a "last" transfer. A design that ignored end of packet would run the full count and report residual 0; one that honoured it on a "more" transfer would stop short. It checks that quad operations make a single beat with a large count and that a zero count makes no beat, since an off-by-one move counter would spin 256 beats. A wait released by a device status change must hold off the write-back until the release, and a design that wrote early would show a status while still active. A branch chain wrapping from the last slot to slot 0 catches a wrong next-slot computation, and the stop slot is checked to stay unwritten.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int DEV_W = 8;
  localparam int STS_W = 16;

  typedef enum logic [2:0] {
    OP_OUT_MORE = 3'd0,
    OP_OUT_LAST = 3'd1,
    OP_IN_MORE  = 3'd2,
    OP_IN_LAST  = 3'd3,
    OP_STQ      = 3'd4,
    OP_LDQ      = 3'd5,
    OP_NOP      = 3'd6,
    OP_STOP     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CC_NEVER  = 2'd0,
    CC_HIT    = 2'd1,
    CC_MISS   = 2'd2,
    CC_ALWAYS = 2'd3
  } cc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_MOVE, S_HOLD, S_DONE
  } st_e;

  function automatic logic cc_apply(input logic [1:0] code, input logic hit);
    case (cc_e'(code))
      CC_NEVER:  return 1'b0;
      CC_HIT:    return hit;
      CC_MISS:   return !hit;
      default:   return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dsq_match.sv
module dsq_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] value,
  output logic         hit
);
  assign hit = ((status & mask) == value);
endmodule

// File: rtl/dsq_desc_mem.sv
module dsq_desc_mem
  import dsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 8,
  parameter int DESC_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [SLOT_W-1:0] host_slot,
  input  logic [DESC_W-1:0] host_wdata,
  output logic [STS_W-1:0]  host_sts,
  output logic [CNT_W-1:0]  host_res,
  input  logic [SLOT_W-1:0] eng_slot,
  output logic [DESC_W-1:0] eng_desc,
  input  logic              wb_en,
  input  logic [STS_W-1:0]  wb_sts,
  input  logic [CNT_W-1:0]  wb_res
);
  logic [DESC_W-1:0] desc_q [DEPTH];
  logic [STS_W-1:0]  sts_q  [DEPTH];
  logic [CNT_W-1:0]  res_q  [DEPTH];

  always_ff @(posedge clk) begin
    if (host_we) desc_q[host_slot] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        sts_q[i] <= '0;
        res_q[i] <= '0;
      end
    end else if (wb_en) begin
      sts_q[eng_slot] <= wb_sts;
      res_q[eng_slot] <= wb_res;
    end else if (host_we) begin
      sts_q[host_slot] <= '0;
      res_q[host_slot] <= '0;
    end
  end

  assign eng_desc = desc_q[eng_slot];
  assign host_sts = sts_q[host_slot];
  assign host_res = res_q[host_slot];

  // R4: a residual never exceeds the count of the descriptor it completes
  assert_resid_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_res <= eng_desc[CNT_W-1:0]));
  // R11: every written status carries the run and active marks
  assert_sts_marks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_sts[15] && wb_sts[10]));
endmodule

// File: rtl/dsq_engine.sv
module dsq_engine
  import dsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SLOT_W = 3,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DESC_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [DESC_W-1:0] desc,
  output logic [SLOT_W-1:0] slot,
  input  logic [DEV_W-1:0]  dev_status,
  input  logic              hit_int,
  input  logic              hit_br,
  input  logic              hit_wt,
  output logic              xfer_req,
  output logic [2:0]        xfer_op,
  output logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_ack,
  input  logic              xfer_eop,
  output logic              wb_en,
  output logic [STS_W-1:0]  wb_sts,
  output logic [CNT_W-1:0]  wb_res,
  output logic              irq,
  output logic              active
);
  localparam int ADDR_LSB = CNT_W;
  localparam int TGT_LSB  = ADDR_LSB + ADDR_W;
  localparam int WT_LSB   = TGT_LSB + SLOT_W;
  localparam int BR_LSB   = WT_LSB + 2;
  localparam int INT_LSB  = BR_LSB + 2;
  localparam int OP_LSB   = INT_LSB + 2;

  st_e               state_q, state_d;
  op_e               op_q, op_d;
  logic [1:0]        ic_q, ic_d, bc_q, bc_d, wc_q, wc_d;
  logic [SLOT_W-1:0] pc_q, pc_d, tgt_q, tgt_d, pc_nx;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              irq_q, irq_d;

  op_e               f_op;
  logic [CNT_W-1:0]  f_cnt;
  logic              is_last, is_quad, wait_hold, br_take;

  assign f_op      = op_e'(desc[OP_LSB +: 3]);
  assign f_cnt     = desc[CNT_W-1:0];
  assign is_last   = (op_q == OP_OUT_LAST) || (op_q == OP_IN_LAST);
  assign is_quad   = (op_q == OP_STQ) || (op_q == OP_LDQ);
  assign wait_hold = cc_apply(wc_q, hit_wt);
  assign br_take   = cc_apply(bc_q, hit_br);
  assign pc_nx     = (pc_q == SLOT_W'(DEPTH - 1)) ? '0 : pc_q + SLOT_W'(1);

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    ic_d    = ic_q;
    bc_d    = bc_q;
    wc_d    = wc_q;
    tgt_d   = tgt_q;
    pc_d    = pc_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    irq_d   = 1'b0;
    wb_en   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        pc_d    = start_slot;
        state_d = S_FETCH;
      end
      S_FETCH: begin
        op_d   = f_op;
        ic_d   = desc[INT_LSB +: 2];
        bc_d   = desc[BR_LSB +: 2];
        wc_d   = desc[WT_LSB +: 2];
        tgt_d  = desc[TGT_LSB +: SLOT_W];
        addr_d = desc[ADDR_LSB +: ADDR_W];
        rem_d  = f_cnt;
        case (f_op)
          OP_STOP: state_d = S_IDLE;
          OP_NOP:  state_d = S_HOLD;
          OP_STQ, OP_LDQ: begin
            rem_d   = CNT_W'(1);
            state_d = S_MOVE;
          end
          default: state_d = (f_cnt == '0) ? S_HOLD : S_MOVE;
        endcase
      end
      S_MOVE: if (xfer_ack) begin
        rem_d  = rem_q - CNT_W'(1);
        addr_d = addr_q + ADDR_W'(1);
        if ((rem_q == CNT_W'(1)) || (is_last && xfer_eop)) state_d = S_HOLD;
      end
      S_HOLD: if (!wait_hold) state_d = S_DONE;
      S_DONE: begin
        wb_en   = 1'b1;
        pc_d    = br_take ? tgt_q : pc_nx;
        irq_d   = cc_apply(ic_q, hit_int);
        state_d = S_FETCH;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_OUT_MORE;
      ic_q    <= '0;
      bc_q    <= '0;
      wc_q    <= '0;
      tgt_q   <= '0;
      pc_q    <= '0;
      rem_q   <= '0;
      addr_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      ic_q    <= ic_d;
      bc_q    <= bc_d;
      wc_q    <= wc_d;
      tgt_q   <= tgt_d;
      pc_q    <= pc_d;
      rem_q   <= rem_d;
      addr_q  <= addr_d;
      irq_q   <= irq_d;
    end
  end

  assign slot      = pc_q;
  assign xfer_req  = (state_q == S_MOVE);
  assign xfer_op   = op_q;
  assign xfer_addr = addr_q;
  assign wb_sts    = {1'b1, 4'b0000, 1'b1, 1'b0, br_take, dev_status};
  assign wb_res    = rem_q;
  assign irq       = irq_q;
  assign active    = (state_q != S_IDLE);

  // R3: a beat is only requested while bytes remain
  assert_req_has_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (rem_q != '0));
  // R5: a quad operation leaves the move phase after its single beat
  assert_quad_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && is_quad && xfer_ack) |=> (state_q == S_HOLD));
  // R7: fetching a stop ends the chain on the next cycle
  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH && f_op == OP_STOP) |=> !active);
  // R10: a holding wait policy keeps the sequencer parked
  assert_wait_parks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HOLD && wait_hold) |=> (state_q == S_HOLD));
  // R12: the interrupt follows a write-back and lasts one cycle
  assert_irq_after_wb_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wb_en));
  assert_irq_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R12: beat, write-back and interrupt never coincide
  assert_phase_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_req, wb_en, irq}));
endmodule

// File: rtl/dsq_top.sv
module dsq_top
  import dsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int DESC_W = 9 + SLOT_W + ADDR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [7:0]        dev_status,
  input  logic [7:0]        int_mask,
  input  logic [7:0]        int_val,
  input  logic [7:0]        br_mask,
  input  logic [7:0]        br_val,
  input  logic [7:0]        wait_mask,
  input  logic [7:0]        wait_val,
  input  logic              host_we,
  input  logic [SLOT_W-1:0] host_slot,
  input  logic [DESC_W-1:0] host_wdata,
  output logic [15:0]       host_sts,
  output logic [CNT_W-1:0]  host_res,
  output logic              xfer_req,
  output logic [2:0]        xfer_op,
  output logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_ack,
  input  logic              xfer_eop,
  output logic              irq,
  output logic              active
);
  localparam int N_SEL = 3;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [DEV_W-1:0] sel_m [N_SEL];
  logic [DEV_W-1:0] sel_v [N_SEL];
  logic [N_SEL-1:0] hits;

  assign sel_m[0] = int_mask;  assign sel_v[0] = int_val;
  assign sel_m[1] = br_mask;   assign sel_v[1] = br_val;
  assign sel_m[2] = wait_mask; assign sel_v[2] = wait_val;

  for (genvar g = 0; g < N_SEL; g++) begin : g_sel
    dsq_match #(.W(DEV_W)) u_match (
      .status(dev_status), .mask(sel_m[g]), .value(sel_v[g]), .hit(hits[g])
    );
  end

  logic [SLOT_W-1:0] eng_slot;
  logic [DESC_W-1:0] eng_desc;
  logic              wb_en;
  logic [STS_W-1:0]  wb_sts;
  logic [CNT_W-1:0]  wb_res;

  dsq_desc_mem #(
    .DEPTH(DEPTH), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .DESC_W(DESC_W)
  ) u_mem (
    .clk(clk), .rst_n(rst_n_s),
    .host_we(host_we), .host_slot(host_slot), .host_wdata(host_wdata),
    .host_sts(host_sts), .host_res(host_res),
    .eng_slot(eng_slot), .eng_desc(eng_desc),
    .wb_en(wb_en), .wb_sts(wb_sts), .wb_res(wb_res)
  );

  dsq_engine #(
    .DEPTH(DEPTH), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DESC_W(DESC_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n_s),
    .start(start), .start_slot(start_slot),
    .desc(eng_desc), .slot(eng_slot), .dev_status(dev_status),
    .hit_int(hits[0]), .hit_br(hits[1]), .hit_wt(hits[2]),
    .xfer_req(xfer_req), .xfer_op(xfer_op), .xfer_addr(xfer_addr),
    .xfer_ack(xfer_ack), .xfer_eop(xfer_eop),
    .wb_en(wb_en), .wb_sts(wb_sts), .wb_res(wb_res),
    .irq(irq), .active(active)
  );
endmodule

// File: tb/test_dsq_top.sv
module test_dsq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  start_slot = '0;
  logic [7:0]  dev_status = '0;
  logic        host_we = 1'b0;
  logic [2:0]  host_slot = '0;
  logic [27:0] host_wdata = '0;
  logic [15:0] host_sts;
  logic [7:0]  host_res;
  logic        xfer_req, irq, active;
  logic [2:0]  xfer_op;
  logic [7:0]  xfer_addr;
  logic        xfer_ack, xfer_eop;

  int n_chk = 0, n_bad = 0;
  int beat_cnt = 0, mark = 0, eop_at = 0, irq_cnt = 0;
  logic [7:0] first_addr, last_addr;
  logic [2:0] seen_op;

  always #10 clk = ~clk;

  dsq_top i_dsq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .start_slot(start_slot),
    .dev_status(dev_status),
    .int_mask(8'h01), .int_val(8'h01), .br_mask(8'h02), .br_val(8'h02),
    .wait_mask(8'h04), .wait_val(8'h04),
    .host_we(host_we), .host_slot(host_slot), .host_wdata(host_wdata),
    .host_sts(host_sts), .host_res(host_res),
    .xfer_req(xfer_req), .xfer_op(xfer_op), .xfer_addr(xfer_addr),
    .xfer_ack(xfer_ack), .xfer_eop(xfer_eop), .irq(irq), .active(active)
  );

  assign xfer_ack = xfer_req;
  assign xfer_eop = xfer_req && ((beat_cnt - mark + 1) == eop_at);

  always @(posedge clk) begin
    if (xfer_req && xfer_ack) begin
      if (beat_cnt == mark) first_addr <= xfer_addr;
      last_addr <= xfer_addr;
      seen_op   <= xfer_op;
      beat_cnt  <= beat_cnt + 1;
    end
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ic, bc, wc;
    logic [7:0]  cnt, eop, dev, beats, resid;
    logic [15:0] sts;
    logic        irq, br;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd3, 2'd0, 2'd0, 8'd4, 8'd0, 8'h00, 8'd4, 8'd0, 16'h8400, 1'b1, 1'b0},
    '{3'd1, 2'd0, 2'd3, 2'd0, 8'd5, 8'd2, 8'h10, 8'd2, 8'd3, 16'h8510, 1'b0, 1'b1},
    '{3'd2, 2'd1, 2'd1, 2'd1, 8'd3, 8'd1, 8'h03, 8'd3, 8'd0, 16'h8503, 1'b1, 1'b1},
    '{3'd3, 2'd2, 2'd2, 2'd0, 8'd6, 8'd0, 8'h03, 8'd6, 8'd0, 16'h8403, 1'b0, 1'b0},
    '{3'd4, 2'd2, 2'd2, 2'd0, 8'd9, 8'd0, 8'h00, 8'd1, 8'd0, 16'h8500, 1'b1, 1'b1},
    '{3'd5, 2'd1, 2'd0, 2'd0, 8'd7, 8'd0, 8'h01, 8'd1, 8'd0, 16'h8401, 1'b1, 1'b0},
    '{3'd6, 2'd0, 2'd1, 2'd0, 8'd5, 8'd0, 8'h02, 8'd0, 8'd5, 16'h8502, 1'b0, 1'b1},
    '{3'd0, 2'd3, 2'd0, 2'd0, 8'd0, 8'd0, 8'h00, 8'd0, 8'd0, 16'h8400, 1'b1, 1'b0},
    '{3'd1, 2'd0, 2'd0, 2'd0, 8'd1, 8'd1, 8'h20, 8'd1, 8'd0, 16'h8420, 1'b0, 1'b0}
  };

  function automatic logic [27:0] mk(input logic [2:0] op, input logic [1:0] ic,
      input logic [1:0] bc, input logic [1:0] wc, input logic [2:0] tgt,
      input logic [7:0] addr, input logic [7:0] cnt);
    return {op, ic, bc, wc, tgt, addr, cnt};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] s, input logic [27:0] d);
    @(negedge clk);
    host_we = 1'b1; host_slot = s; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [2:0] s, output int sts, output int res);
    @(negedge clk);
    host_slot = s;
    #1;
    sts = int'(host_sts);
    res = int'(host_res);
  endtask

  task automatic kick(input logic [2:0] s);
    @(negedge clk);
    mark = beat_cnt;
    start = 1'b1; start_slot = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!active) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int sts, res, irq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 active", int'(active), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 xfer_req", int'(xfer_req), 0);
    hread(3'd0, sts, res);
    check("R1 status", sts, 0);
    check("R1 residual", res, 0);

    // vector table: one descriptor at slot 0, stop at 1, no-op at 2, stop at 3
    for (int i = 0; i < NV; i++) begin
      hwrite(3'd0, mk(VEC[i].op, VEC[i].ic, VEC[i].bc, VEC[i].wc, 3'd2,
                      8'(8'h40 + i), VEC[i].cnt));
      hwrite(3'd1, mk(3'd7, 2'd0, 2'd0, 2'd0, 3'd0, 8'h00, 8'd0));
      hwrite(3'd2, mk(3'd6, 2'd0, 2'd0, 2'd0, 3'd0, 8'h00, 8'd5));
      hwrite(3'd3, mk(3'd7, 2'd0, 2'd0, 2'd0, 3'd0, 8'h00, 8'd0));
      dev_status = VEC[i].dev;
      eop_at = int'(VEC[i].eop);
      irq0 = irq_cnt;
      kick(3'd0);
      wait_idle();
      check("R3 R4 R5 R6 beat count", beat_cnt - mark, int'(VEC[i].beats));
      if (VEC[i].beats != 0) begin
        check("R3 first address", int'(first_addr), 8'h40 + i);
        check("R3 last address", int'(last_addr), 8'h40 + i + int'(VEC[i].beats) - 1);
        check("R3 R5 opcode shown", int'(seen_op), int'(VEC[i].op));
      end
      hread(3'd0, sts, res);
      check("R11 status", sts, int'(VEC[i].sts));
      check("R4 R5 R6 residual", res, int'(VEC[i].resid));
      check("R8 R12 interrupt count", irq_cnt - irq0, int'(VEC[i].irq));
      hread(3'd2, sts, res);
      check("R9 R8 branch path", int'(sts != 0), int'(VEC[i].br));
      hread(3'd1, sts, res);
      check("R7 stop slot unwritten", sts, 0);
    end

    // R10: wait held by device status bit 2, then released
    eop_at = 0;
    hwrite(3'd0, mk(3'd2, 2'd3, 2'd0, 2'd1, 3'd0, 8'h80, 8'd2));
    hwrite(3'd1, mk(3'd7, 2'd0, 2'd0, 2'd0, 3'd0, 8'h00, 8'd0));
    dev_status = 8'h04;
    irq0 = irq_cnt;
    kick(3'd0);
    repeat (20) @(negedge clk);
    check("R10 beats before release", beat_cnt - mark, 2);
    check("R10 still active", int'(active), 1);
    hread(3'd0, sts, res);
    check("R10 no write-back while waiting", sts, 0);
    check("R10 no interrupt while waiting", irq_cnt - irq0, 0);
    dev_status = 8'h00;
    wait_idle();
    hread(3'd0, sts, res);
    check("R10 status after release", sts, 16'h8400);
    check("R12 interrupt after release", irq_cnt - irq0, 1);

    // R9: chain 7 -> wrap to 0 -> branch to 5 -> stop at 6
    hwrite(3'd7, mk(3'd6, 2'd0, 2'd0, 2'd0, 3'd0, 8'h00, 8'd1));
    hwrite(3'd0, mk(3'd0, 2'd0, 2'd3, 2'd0, 3'd5, 8'h10, 8'd2));
    hwrite(3'd1, mk(3'd7, 2'd0, 2'd0, 2'd0, 3'd0, 8'h00, 8'd0));
    hwrite(3'd5, mk(3'd6, 2'd0, 2'd0, 2'd0, 3'd0, 8'h00, 8'd3));
    hwrite(3'd6, mk(3'd7, 2'd0, 2'd0, 2'd0, 3'd0, 8'h00, 8'd0));
    kick(3'd7);
    wait_idle();
    check("R9 chain beats", beat_cnt - mark, 2);
    hread(3'd7, sts, res);
    check("R6 no-op residual slot 7", res, 1);
    check("R11 no-op status slot 7", sts, 16'h8400);
    hread(3'd0, sts, res);
    check("R9 wrapped slot 0 status", sts, 16'h8500);
    hread(3'd5, sts, res);
    check("R9 branch target residual", res, 3);
    hread(3'd1, sts, res);
    check("R9 skipped slot unwritten", sts, 0);

    // R2: host write clears status and residual
    hwrite(3'd5, mk(3'd7, 2'd0, 2'd0, 2'd0, 3'd0, 8'h00, 8'd0));
    hread(3'd5, sts, res);
    check("R2 cleared status", sts, 0);
    check("R2 cleared residual", res, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule